// File: doc/BRIEF.md
# Split I/D Cache Request Steering

This block sits in front of the coherence controller of a split first-level cache. Each processor request carries a request type (load, store, atomic or instruction fetch) and a line address. The block looks the address up in the tag stores of both the instruction cache and the data cache. In the same cycle it tells the controller which single action to take. The action is one of: a hit in the cache that serves the request, a miss that can be filled into a free way, an eviction of the line from the wrong cache, or an eviction of a victim line to make room.

The block keeps a line out of both caches at the same time. A request that finds its line in the other cache first asks for that copy to be evicted. A request that finds its set full first asks for the least recently used way to be evicted. In both of these cases the request stays at the head of its queue. It is evaluated again once the controller reports that the line has been deallocated. A single request can therefore produce a chain of events, such as an eviction from the wrong cache, then a victim eviction, then a miss. Messages from the next-level cache always take precedence over processor requests.

The tag stores live in this block. The controller updates them through an allocate port and a deallocate port. Each cache is 4-way set associative, uses true LRU replacement and prefers invalid ways. Every hit marks the way it used as most recently used.

Top module: `ic_dc_steer`

## Requirements
- R1: The request type maps to the event type as follows: reqType 0 (load) gives evType 0 (Load), reqType 1 (store) and reqType 2 (atomic) both give evType 1 (Store), and reqType 3 (instruction fetch) gives evType 2 (Ifetch). evType is reported with every event.
- R2: An instruction fetch looks up only the I-cache (evIcache=1), and every other type looks up only the D-cache (evIcache=0). On a tag match the block raises evKind 0 (HIT) with the matching way and asserts reqPop.
- R3: If the request misses its own cache and the line is valid in the other cache, the block raises evKind 2 (REPLACE) for the other cache, with the request's own address and the way that holds it.
- R4: If the request misses both caches and its set in its own cache has an invalid way, the block raises evKind 1 (MISS) with the lowest-numbered invalid way and asserts reqPop.
- R5: If the request misses both caches and its set is full, the block raises evKind 2 (REPLACE) in its own cache for the LRU way. evAddr is that way's line address ({tag, set}).
- R6: reqPop is low on every REPLACE event, so the same request is evaluated again on later cycles.
- R7: While netValid is high, netGrant is high, no event is raised and reqPop stays low.
- R8: A HIT makes the hit way the most recently used way in its own cache. An allocation makes the allocated way the most recently used way.
- R9: Victim choice is true LRU over the 4 ways, and an invalid way is always chosen ahead of any valid one.
- R10: A line address is never valid in both caches at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; clears all valid bits |
| reqValid | input | 1 | A processor request is at the head of its queue |
| reqType | input | 2 | 0 load, 1 store, 2 atomic, 3 instruction fetch |
| reqAddr | input | ADDR_W | Line address of the request; the low SET_W bits select the set |
| netValid | input | 1 | A message from the next-level cache is waiting |
| allocValid | input | 1 | Controller installs allocAddr in the chosen cache |
| allocIcache | input | 1 | 1 selects the I-cache for the allocation, 0 the D-cache |
| allocAddr | input | ADDR_W | Line address to install |
| deallocValid | input | 1 | Controller removes deallocAddr from the chosen cache |
| deallocIcache | input | 1 | 1 selects the I-cache for the removal, 0 the D-cache |
| deallocAddr | input | ADDR_W | Line address to remove |
| netGrant | output | 1 | The network message is served this cycle |
| evValid | output | 1 | An event is presented to the controller |
| evKind | output | 2 | 0 HIT, 1 MISS, 2 REPLACE |
| evType | output | 2 | 0 Load, 1 Store, 2 Ifetch |
| evIcache | output | 1 | The cache the event acts on (1 I-cache, 0 D-cache) |
| evAddr | output | ADDR_W | Line address the event acts on |
| evWay | output | 2 | Way the event acts on |
| reqPop | output | 1 | Dequeue the processor request |

## Verification
On every cycle the assertions check the invariant that no request address hits in both caches, the priority of network messages, that a REPLACE event never dequeues the request, and that a HIT event names the cache its request type calls for. The bench scenarios are needed to show that LRU order follows the sequence of hits and allocations, that an invalid way is taken ahead of the LRU way, and that a request moved between caches runs through its full chain of events as the controller deallocates lines.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS);

  typedef enum logic [1:0] {
    REQ_LOAD   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_ATOMIC = 2'd2,
    REQ_IFETCH = 2'd3
  } reqTypeT;

  typedef enum logic [1:0] {
    EV_HIT     = 2'd0,
    EV_MISS    = 2'd1,
    EV_REPLACE = 2'd2
  } evKindT;

  typedef enum logic [1:0] {
    ET_LOAD   = 2'd0,
    ET_STORE  = 2'd1,
    ET_IFETCH = 2'd2
  } evTypeT;

  // control -> datapath strobes
  typedef struct packed {
    logic             touch;
    logic             touchIcache;
    logic [WAY_W-1:0] touchWay;
  } strobeT;

endpackage

// File: rtl/steer_tags.sv
module steer_tags
  import steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SETS   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           lookupAddr,
  input  strobeT                      strobes,
  input  logic                        allocValid,
  input  logic                        allocIcache,
  input  logic [ADDR_W-1:0]           allocAddr,
  input  logic                        deallocValid,
  input  logic                        deallocIcache,
  input  logic [ADDR_W-1:0]           deallocAddr,
  output logic [1:0]                  hit,
  output logic [1:0][WAY_W-1:0]       hitWay,
  output logic [1:0]                  freeAvail,
  output logic [1:0][WAY_W-1:0]       freeWay,
  output logic [1:0][WAY_W-1:0]       lruWay,
  output logic [1:0][ADDR_W-1:0]      lruAddr
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - SET_W;

  logic [SET_W-1:0] lkIdx, alIdx, dlIdx;
  logic [TAG_W-1:0] lkTag, alTag, dlTag;
  assign lkIdx = lookupAddr[SET_W-1:0];
  assign lkTag = lookupAddr[ADDR_W-1:SET_W];
  assign alIdx = allocAddr[SET_W-1:0];
  assign alTag = allocAddr[ADDR_W-1:SET_W];
  assign dlIdx = deallocAddr[SET_W-1:0];
  assign dlTag = deallocAddr[ADDR_W-1:SET_W];

  // index 0 = D-cache, index 1 = I-cache
  for (genvar c = 0; c < 2; c++) begin : g_cache
    logic [TAG_W-1:0] tagMem [SETS][NUM_WAYS];
    logic             vld    [SETS][NUM_WAYS];
    logic [WAY_W-1:0] age    [SETS][NUM_WAYS];

    logic             cHit, cFree;
    logic [WAY_W-1:0] cHitWay, cFreeWay, cLruWay;
    logic             alMine, dlMine, dlFound;
    logic [WAY_W-1:0] alWay, dlWay;
    logic             doTouch;
    logic [SET_W-1:0] tIdx;
    logic [WAY_W-1:0] tWay;

    always_comb begin
      cHit = 1'b0; cHitWay = '0; cFree = 1'b0; cFreeWay = '0; cLruWay = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
        if (vld[lkIdx][w] && tagMem[lkIdx][w] == lkTag) begin
          cHit = 1'b1; cHitWay = WAY_W'(w);
        end
        if (!vld[lkIdx][w]) begin
          cFree = 1'b1; cFreeWay = WAY_W'(w);
        end
        if (age[lkIdx][w] == WAY_W'(NUM_WAYS - 1)) cLruWay = WAY_W'(w);
      end
    end

    always_comb begin
      alMine = allocValid && (allocIcache == 1'(c));
      dlMine = deallocValid && (deallocIcache == 1'(c));
      alWay = '0; dlFound = 1'b0; dlWay = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--)
        if (age[alIdx][w] == WAY_W'(NUM_WAYS - 1)) alWay = WAY_W'(w);
      for (int w = NUM_WAYS - 1; w >= 0; w--)
        if (!vld[alIdx][w]) alWay = WAY_W'(w);
      for (int w = 0; w < NUM_WAYS; w++)
        if (vld[dlIdx][w] && tagMem[dlIdx][w] == dlTag) begin
          dlFound = 1'b1; dlWay = WAY_W'(w);
        end
      doTouch = alMine || (strobes.touch && strobes.touchIcache == 1'(c));
      tIdx    = alMine ? alIdx : lkIdx;
      tWay    = alMine ? alWay : strobes.touchWay;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < NUM_WAYS; w++) begin
            vld[s][w]    <= 1'b0;
            age[s][w]    <= WAY_W'(w);
            tagMem[s][w] <= '0;
          end
      end else begin
        if (dlMine && dlFound) vld[dlIdx][dlWay] <= 1'b0;
        if (alMine) begin
          vld[alIdx][alWay]    <= 1'b1;
          tagMem[alIdx][alWay] <= alTag;
        end
        if (doTouch)
          for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == tWay) age[tIdx][w] <= '0;
            else if (age[tIdx][w] < age[tIdx][tWay]) age[tIdx][w] <= age[tIdx][w] + 1'b1;
          end
      end
    end

    assign hit[c]       = cHit;
    assign hitWay[c]    = cHitWay;
    assign freeAvail[c] = cFree;
    assign freeWay[c]   = cFreeWay;
    assign lruWay[c]    = cLruWay;
    assign lruAddr[c]   = {tagMem[lkIdx][cLruWay], lkIdx};
  end

endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                   reqValid,
  input  logic [1:0]             reqType,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   netValid,
  input  logic [1:0]             hit,
  input  logic [1:0][WAY_W-1:0]  hitWay,
  input  logic [1:0]             freeAvail,
  input  logic [1:0][WAY_W-1:0]  freeWay,
  input  logic [1:0][WAY_W-1:0]  lruWay,
  input  logic [1:0][ADDR_W-1:0] lruAddr,
  output strobeT                 strobes,
  output logic                   netGrant,
  output logic                   evValid,
  output logic [1:0]             evKind,
  output logic [1:0]             evType,
  output logic                   evIcache,
  output logic [ADDR_W-1:0]      evAddr,
  output logic [WAY_W-1:0]       evWay,
  output logic                   reqPop
);
  logic own, other;

  always_comb begin
    own      = (reqType == REQ_IFETCH);
    other    = !own;
    netGrant = netValid;
    evValid  = reqValid && !netValid;
    unique case (reqType)
      REQ_LOAD:   evType = ET_LOAD;
      REQ_IFETCH: evType = ET_IFETCH;
      default:    evType = ET_STORE;
    endcase
    evKind   = EV_REPLACE;
    evIcache = own;
    evAddr   = reqAddr;
    evWay    = '0;
    reqPop   = 1'b0;
    strobes  = '0;
    if (hit[own]) begin
      evKind = EV_HIT; evWay = hitWay[own]; reqPop = evValid;
      strobes.touch = evValid; strobes.touchIcache = own; strobes.touchWay = hitWay[own];
    end else if (hit[other]) begin
      evIcache = other; evWay = hitWay[other];
    end else if (freeAvail[own]) begin
      evKind = EV_MISS; evWay = freeWay[own]; reqPop = evValid;
    end else begin
      evAddr = lruAddr[own]; evWay = lruWay[own];
    end
  end

endmodule

// File: rtl/ic_dc_steer.sv
module ic_dc_steer
  import steer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SETS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              netValid,
  input  logic              allocValid,
  input  logic              allocIcache,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              deallocValid,
  input  logic              deallocIcache,
  input  logic [ADDR_W-1:0] deallocAddr,
  output logic              netGrant,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [1:0]        evType,
  output logic              evIcache,
  output logic [ADDR_W-1:0] evAddr,
  output logic [WAY_W-1:0]  evWay,
  output logic              reqPop
);
  strobeT                 strobes;
  logic [1:0]             dpHit, dpFree;
  logic [1:0][WAY_W-1:0]  dpHitWay, dpFreeWay, dpLruWay;
  logic [1:0][ADDR_W-1:0] dpLruAddr;

  steer_tags #(.ADDR_W(ADDR_W), .SETS(SETS)) i_tags (
    .clk(clk), .rstN(rstN), .lookupAddr(reqAddr), .strobes(strobes),
    .allocValid(allocValid), .allocIcache(allocIcache), .allocAddr(allocAddr),
    .deallocValid(deallocValid), .deallocIcache(deallocIcache), .deallocAddr(deallocAddr),
    .hit(dpHit), .hitWay(dpHitWay), .freeAvail(dpFree), .freeWay(dpFreeWay),
    .lruWay(dpLruWay), .lruAddr(dpLruAddr)
  );

  steer_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .reqValid(reqValid), .reqType(reqType), .reqAddr(reqAddr), .netValid(netValid),
    .hit(dpHit), .hitWay(dpHitWay), .freeAvail(dpFree), .freeWay(dpFreeWay),
    .lruWay(dpLruWay), .lruAddr(dpLruAddr), .strobes(strobes),
    .netGrant(netGrant), .evValid(evValid), .evKind(evKind), .evType(evType),
    .evIcache(evIcache), .evAddr(evAddr), .evWay(evWay), .reqPop(reqPop)
  );

endmodule

// File: rtl/ic_dc_steer_checker.sv
module ic_dc_steer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqType,
  input logic       netValid,
  input logic [1:0] dpHit,
  input logic       evValid,
  input logic [1:0] evKind,
  input logic       evIcache,
  input logic       reqPop
);
  // R10: exclusivity of the two tag stores for the looked-up line
  a_r10_not_in_both: assert property (@(posedge clk) disable iff (!rstN)
    !(dpHit[0] && dpHit[1]));

  // R7: network messages win
  a_r7_net_priority: assert property (@(posedge clk) disable iff (!rstN)
    netValid |-> (!evValid && !reqPop));

  // R7: a processor request alone always produces an event
  a_r7_req_served: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !netValid) |-> evValid);

  // R6: replacement keeps the request queued
  a_r6_replace_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evKind == 2'd2) |-> !reqPop);

  // R2: a hit is reported on the cache the type selects
  a_r2_hit_cache: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evKind == 2'd0) |-> (evIcache == (reqType == 2'd3)));

  // R4: hits and misses dequeue the request
  a_r4_pop_on_fill: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evKind != 2'd2) |-> reqPop);
endmodule

bind ic_dc_steer ic_dc_steer_checker i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
  .netValid(netValid), .dpHit(dpHit), .evValid(evValid), .evKind(evKind),
  .evIcache(evIcache), .reqPop(reqPop)
);

// File: tb/test_ic_dc_steer.sv
module test_ic_dc_steer;
  localparam int ADDR_W = 12;
  localparam int SETS   = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, netValid = 0, allocValid = 0, allocIcache = 0;
  logic deallocValid = 0, deallocIcache = 0;
  logic [1:0] reqType = 0;
  logic [ADDR_W-1:0] reqAddr = 0, allocAddr = 0, deallocAddr = 0;
  logic netGrant, evValid, evIcache, reqPop;
  logic [1:0] evKind, evType, evWay;
  logic [ADDR_W-1:0] evAddr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ic_dc_steer #(.ADDR_W(ADDR_W), .SETS(SETS)) i_ic_dc_steer (.*);

  function automatic logic [ADDR_W-1:0] la(int tag, int set);
    return ADDR_W'(tag * SETS + set);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // present request and check combinational event (valid,kind,type,icache,addr,way,pop)
  task automatic look(string req, logic [1:0] t, logic [ADDR_W-1:0] a,
                      logic [1:0] k, logic [1:0] et, logic ic,
                      logic [ADDR_W-1:0] ea, logic [1:0] w, logic pop);
    @(negedge clk);
    reqValid = 1; reqType = t; reqAddr = a;
    #1;
    chk({req, " evValid"}, 32'(evValid), 32'd1);
    chk({req, " evKind"}, 32'(evKind), 32'(k));
    chk({req, " evType"}, 32'(evType), 32'(et));
    chk({req, " evIcache"}, 32'(evIcache), 32'(ic));
    chk({req, " evAddr"}, 32'(evAddr), 32'(ea));
    chk({req, " evWay"}, 32'(evWay), 32'(w));
    chk({req, " reqPop"}, 32'(reqPop), 32'(pop));
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic alloc(logic ic, logic [ADDR_W-1:0] a);
    @(negedge clk);
    allocValid = 1; allocIcache = ic; allocAddr = a;
    @(negedge clk);
    allocValid = 0;
  endtask

  task automatic dealloc(logic ic, logic [ADDR_W-1:0] a);
    @(negedge clk);
    deallocValid = 1; deallocIcache = ic; deallocAddr = a;
    @(negedge clk);
    deallocValid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset evValid", 32'(evValid), 0);
    chk("reset reqPop", 32'(reqPop), 0);
    // R4: empty cache -> miss in way 0
    look("R4 empty load", 2'd0, la(5, 1), 2'd1, 2'd0, 1'b0, la(5, 1), 2'd0, 1'b1);
  endtask

  task automatic t_hits;
    alloc(1'b0, la(5, 1));
    look("R2 R1 load hit", 2'd0, la(5, 1), 2'd0, 2'd0, 1'b0, la(5, 1), 2'd0, 1'b1);
    look("R1 store hit", 2'd1, la(5, 1), 2'd0, 2'd1, 1'b0, la(5, 1), 2'd0, 1'b1);
    look("R1 atomic hit", 2'd2, la(5, 1), 2'd0, 2'd1, 1'b0, la(5, 1), 2'd0, 1'b1);
  endtask

  task automatic t_wrongCache;
    // R3: ifetch of a D-resident line evicts it from D first, request stays (R6)
    look("R3 ifetch in D", 2'd3, la(5, 1), 2'd2, 2'd2, 1'b0, la(5, 1), 2'd0, 1'b0);
    dealloc(1'b0, la(5, 1));
    look("R4 R1 ifetch miss", 2'd3, la(5, 1), 2'd1, 2'd2, 1'b1, la(5, 1), 2'd0, 1'b1);
    alloc(1'b1, la(5, 1));
    look("R2 ifetch hit", 2'd3, la(5, 1), 2'd0, 2'd2, 1'b1, la(5, 1), 2'd0, 1'b1);
    // R3 the other direction: load of an I-resident line
    look("R3 load in I", 2'd0, la(5, 1), 2'd2, 2'd0, 1'b1, la(5, 1), 2'd0, 1'b0);
    dealloc(1'b1, la(5, 1));
  endtask

  task automatic t_net;
    @(negedge clk);
    reqValid = 1; reqType = 2'd0; reqAddr = la(9, 2); netValid = 1;
    #1;
    chk("R7 netGrant", 32'(netGrant), 1);
    chk("R7 evValid", 32'(evValid), 0);
    chk("R7 reqPop", 32'(reqPop), 0);
    @(negedge clk);
    reqValid = 0; netValid = 0;
  endtask

  task automatic t_lru;
    for (int i = 0; i < 4; i++) alloc(1'b0, la(i + 1, 3));
    // R5 R9: set full, LRU is way 0 (first allocated)
    look("R5 victim", 2'd0, la(20, 3), 2'd2, 2'd0, 1'b0, la(1, 3), 2'd0, 1'b0);
    // R8: hit on way 0 makes it MRU; next LRU is way 1
    look("R8 hit way0", 2'd1, la(1, 3), 2'd0, 2'd1, 1'b0, la(1, 3), 2'd0, 1'b1);
    look("R8 R9 new victim", 2'd0, la(20, 3), 2'd2, 2'd0, 1'b0, la(2, 3), 2'd1, 1'b0);
    // R9: invalid way preferred over LRU way 1
    dealloc(1'b0, la(3, 3));
    look("R9 free way", 2'd0, la(20, 3), 2'd1, 2'd0, 1'b0, la(20, 3), 2'd2, 1'b1);
    // R8: allocation makes way 2 MRU; LRU still way 1
    alloc(1'b0, la(20, 3));
    look("R8 alloc mru", 2'd0, la(21, 3), 2'd2, 2'd0, 1'b0, la(2, 3), 2'd1, 1'b0);
  endtask

  task automatic t_excl;
    // R10: chain for an ifetch of a D-resident line in a full I set
    for (int i = 0; i < 4; i++) alloc(1'b1, la(i + 1, 4));
    alloc(1'b0, la(9, 4));
    look("R10 R3 step1", 2'd3, la(9, 4), 2'd2, 2'd2, 1'b0, la(9, 4), 2'd0, 1'b0);
    dealloc(1'b0, la(9, 4));
    look("R10 R5 step2", 2'd3, la(9, 4), 2'd2, 2'd2, 1'b1, la(1, 4), 2'd0, 1'b0);
    dealloc(1'b1, la(1, 4));
    look("R10 R4 step3", 2'd3, la(9, 4), 2'd1, 2'd2, 1'b1, la(9, 4), 2'd0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_hits();
    t_wrongCache();
    t_net();
    t_lru();
    t_excl();
    done = 1;
  end

  initial begin : watchdog
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule